// File: doc/BRIEF.md
# Character-Cell Screen Address Generator

This block computes the display memory address of every byte a video fetch engine reads from a frame buffer stored in character-cell order. In that order a cell column is eight consecutive bytes, one per pixel line. So moving to the next byte on a line adds 8 to the address, moving down one line inside a cell adds 1, and crossing into the next text row steps back by 7. The screen occupies the top of a 32 KiB window ending at 0x8000. Any address that reaches or passes that limit is folded back by the screen size, which gives a circular buffer.

Seven display modes (0 to 6) fix the line width, the colour depth and the number of text rows. From these the block derives the screen size, the start address and the row height. A fetch engine drives a start-of-frame strobe, an end-of-line strobe, a byte-advance strobe and an active-frame flag. The block returns the fetch address and a flag that is low on the blank spacer lines of the 25-row modes. The mode input is latched only at start of frame.

Top module: `ccag_addr_gen`

## Requirements
- R1: While reset is high and in the cycle after it, `addr_o` is 0x6000 and `in_char_line_o` is 1, which is the geometry of mode 6 (10-line rows, screen size 0x2000).
- R2: A start-of-frame strobe loads the address and the line-start register with the start of the mode on `mode_i`: 0x3000 for modes 0, 1 and 2, 0x4100 for mode 3, 0x5800 for modes 4 and 5, and 0x6000 for modes 6 and 7. The screen size is 0x8000 minus the start. The line counter loads the start modulo 8.
- R3: `mode_i` is sampled only on a start-of-frame strobe. In all other cycles it has no effect on the wrap size or the row height.
- R4: A byte-advance strobe taken with `active_i` high on a character line adds 8 to `addr_o`. The new address shows one cycle later.
- R5: Every computed address that is 0x8000 or more has the current screen size subtracted from it, so `addr_o` always stays below 0x8000.
- R6: The first end-of-line strobe with `active_i` high after a start of frame does nothing. An end-of-line strobe with `active_i` low also does nothing.
- R7: An end-of-line strobe on an inner line (next line count below 8 and below the row height) sets the address to line-start + 1, wrapped, and records that value as the new line-start.
- R8: When the line count reaches the row height (8 for modes 0, 1, 2, 4 and 5; 10 for modes 3, 6 and 7), the address is reduced by 7 and wrapped, the line count returns to 0, and line-start takes the new address.
- R9: Line counts 8 and 9 of a 10-line row are spacer lines. On them `in_char_line_o` is 0, byte advances are ignored, and an end-of-line strobe that does not end the row leaves the address unchanged.
- R10: Start of frame takes priority over end of line, and end of line takes priority over byte advance, when they arrive in the same cycle.
- R11: With no start of frame, no qualified end of line and no qualified byte advance, `addr_o` and `in_char_line_o` hold. A byte advance with `active_i` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Display mode, latched at start of frame |
| frame_start_i | input | 1 | Start-of-frame strobe |
| line_end_i | input | 1 | End-of-scanline strobe |
| byte_adv_i | input | 1 | One display byte has been fetched |
| active_i | input | 1 | Scanline lies inside the active frame |
| addr_o | output | 16 | Current fetch address |
| in_char_line_o | output | 1 | Current line carries cell data (low on spacer lines) |

## Verification
Every result of this block comes from a register. A strobe seen at one rising edge is visible on `addr_o` and `in_char_line_o` right after that edge and stays there until the next edge. The bench drives each stimulus on a falling edge and updates its reference model at the same moment. It then compares both outputs on the following falling edge, a full clock after the drive and half a clock after the capturing edge. The reset values are sampled while reset is still high. The long directed wrap runs, over 1024 and 2016 byte advances, are read out at the end through the same one-cycle timing.

// File: rtl/ccag_pkg.sv
package ccag_pkg;

  typedef logic [2:0] mode_t;

  // Per-mode shape: visible width in pixels, bits per pixel, text rows.
  typedef struct packed {
    logic [9:0] width;
    logic [2:0] bpp;
    logic [5:0] rows;
  } shape_t;

  function automatic shape_t shape_of(input mode_t m);
    shape_t s;
    case (m)
      3'd0:    s = '{width: 10'd640, bpp: 3'd1, rows: 6'd32};
      3'd1:    s = '{width: 10'd320, bpp: 3'd2, rows: 6'd32};
      3'd2:    s = '{width: 10'd160, bpp: 3'd4, rows: 6'd32};
      3'd3:    s = '{width: 10'd640, bpp: 3'd1, rows: 6'd25};
      3'd4:    s = '{width: 10'd320, bpp: 3'd1, rows: 6'd32};
      3'd5:    s = '{width: 10'd160, bpp: 3'd2, rows: 6'd32};
      default: s = '{width: 10'd320, bpp: 3'd1, rows: 6'd25};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ccag_wrap.sv
// Folds an address that has reached the top of the window back by the
// screen size.
module ccag_wrap #(
  parameter int          ADDR_W       = 16,
  parameter int unsigned SCREEN_LIMIT = 32'h8000
) (
  input  logic [ADDR_W:0]   val_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic [ADDR_W-1:0] val_o
);
  localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(SCREEN_LIMIT);

  logic over;

  always_comb begin
    over  = (val_i >= LIM);
    val_o = val_i[ADDR_W-1:0] - (over ? size_i : '0);
  end
endmodule

// File: rtl/ccag_line_ctrl.sv
// Line-in-row counter. It decides whether an end-of-line strobe is ignored,
// steps to the next inner line, or closes the row.
module ccag_line_ctrl #(
  parameter int CELL_LINES = 8,
  parameter int LINE_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [LINE_W-1:0] load_line_i,
  input  logic              step_i,
  input  logic [LINE_W-1:0] row_h_i,
  output logic              row_wrap_o,
  output logic              inner_o,
  output logic              in_char_o
);
  localparam logic [LINE_W-1:0] CELL = LINE_W'(CELL_LINES);

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] nxt;
  logic              first_q;
  logic              in_char_q;
  logic              live_step;

  always_comb begin
    nxt        = line_q + LINE_W'(1);
    live_step  = step_i && !first_q;
    row_wrap_o = live_step && (nxt == row_h_i);
    inner_o    = live_step && !row_wrap_o && (nxt < CELL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= '0;
      first_q   <= 1'b1;
      in_char_q <= 1'b1;
    end else if (load_i) begin
      line_q    <= load_line_i;
      first_q   <= 1'b1;
      in_char_q <= (load_line_i < CELL);
    end else if (step_i) begin
      if (first_q) begin
        first_q <= 1'b0;
      end else if (row_wrap_o) begin
        line_q    <= '0;
        in_char_q <= 1'b1;
      end else begin
        line_q    <= nxt;
        in_char_q <= (nxt < CELL);
      end
    end
  end

  assign in_char_o = in_char_q;
endmodule

// File: rtl/ccag_addr_gen.sv
module ccag_addr_gen #(
  parameter int          ADDR_W        = 16,
  parameter int unsigned SCREEN_LIMIT  = 32'h8000,
  parameter int          CELL_LINES    = 8,
  parameter int          DISPLAY_LINES = 256,
  parameter int unsigned RESET_MODE    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_i,
  input  logic              frame_start_i,
  input  logic              line_end_i,
  input  logic              byte_adv_i,
  input  logic              active_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              in_char_line_o
);
  import ccag_pkg::*;

  localparam int LINE_W = $clog2(DISPLAY_LINES + 1);
  localparam int STEPS  = 3;  // 0: next byte, 1: next line, 2: next row

  // Geometry derived from the mode table.
  function automatic int unsigned f_start(input mode_t m);
    shape_t      s;
    int unsigned scr;
    s   = shape_of(m);
    scr = (int'(s.width) * int'(s.bpp) / 8) * CELL_LINES * int'(s.rows);
    return (SCREEN_LIMIT - scr) & 32'hFFFF_FF00;
  endfunction

  function automatic int unsigned f_rowh(input mode_t m);
    shape_t s;
    s = shape_of(m);
    return DISPLAY_LINES / int'(s.rows);
  endfunction

  logic [2:0]        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] ls_q;
  logic [ADDR_W-1:0] live_start;
  logic [ADDR_W-1:0] rst_start;
  logic [ADDR_W-1:0] held_size;
  logic [LINE_W-1:0] held_rowh;
  logic [LINE_W-1:0] live_line0;
  logic [ADDR_W:0]   cand    [STEPS];
  logic [ADDR_W-1:0] wrapped [STEPS];
  logic              row_wrap;
  logic              inner;
  logic              in_char;
  logic              line_step;
  logic              byte_ok;

  always_comb begin
    live_start = ADDR_W'(f_start(mode_i));
    rst_start  = ADDR_W'(f_start(3'(RESET_MODE)));
    live_line0 = LINE_W'(f_start(mode_i) % CELL_LINES);
    held_size  = ADDR_W'(SCREEN_LIMIT - f_start(mode_q));
    held_rowh  = LINE_W'(f_rowh(mode_q));
    cand[0]    = (ADDR_W+1)'(addr_q) + (ADDR_W+1)'(CELL_LINES);
    cand[1]    = (ADDR_W+1)'(ls_q) + (ADDR_W+1)'(1);
    cand[2]    = (ADDR_W+1)'(addr_q) - (ADDR_W+1)'(CELL_LINES - 1);
    line_step  = line_end_i && active_i && !frame_start_i;
    byte_ok    = byte_adv_i && active_i && in_char && !line_end_i && !frame_start_i;
  end

  for (genvar k = 0; k < STEPS; k++) begin : g_wrap
    ccag_wrap #(
      .ADDR_W      (ADDR_W),
      .SCREEN_LIMIT(SCREEN_LIMIT)
    ) u_wrap (
      .val_i (cand[k]),
      .size_i(held_size),
      .val_o (wrapped[k])
    );
  end

  ccag_line_ctrl #(
    .CELL_LINES(CELL_LINES),
    .LINE_W    (LINE_W)
  ) u_line (
    .clk        (clk),
    .rst        (rst),
    .load_i     (frame_start_i),
    .load_line_i(live_line0),
    .step_i     (line_step),
    .row_h_i    (held_rowh),
    .row_wrap_o (row_wrap),
    .inner_o    (inner),
    .in_char_o  (in_char)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 3'(RESET_MODE);
      addr_q <= rst_start;
      ls_q   <= rst_start;
    end else if (frame_start_i) begin
      mode_q <= mode_i;
      addr_q <= live_start;
      ls_q   <= live_start;
    end else if (row_wrap) begin
      addr_q <= wrapped[2];
      ls_q   <= wrapped[2];
    end else if (inner) begin
      addr_q <= wrapped[1];
      ls_q   <= wrapped[1];
    end else if (byte_ok) begin
      addr_q <= wrapped[0];
    end
  end

  assign addr_o         = addr_q;
  assign in_char_line_o = in_char;
endmodule

// File: rtl/ccag_addr_gen_chk.sv
module ccag_addr_gen_chk #(
  parameter int          ADDR_W       = 16,
  parameter int unsigned SCREEN_LIMIT = 32'h8000
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start_i,
  input logic              line_end_i,
  input logic              byte_adv_i,
  input logic              active_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              in_char_line_o
);
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    32'(addr_o) < SCREEN_LIMIT); // R5

  AST_BYTE_STEP_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (byte_adv_i && active_i && in_char_line_o && !line_end_i && !frame_start_i)
    |=> (addr_o[2:0] == $past(addr_o[2:0])) && (addr_o != $past(addr_o))); // R4

  AST_FRAME_LOAD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |=> (addr_o[7:0] == 8'h00) && in_char_line_o); // R2

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frame_start_i && !line_end_i && !byte_adv_i)
    |=> $stable(addr_o) && $stable(in_char_line_o)); // R11

  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!active_i && !frame_start_i) |=> $stable(addr_o)); // R6

  AST_SPACER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_char_line_o && !frame_start_i && !line_end_i) |=> $stable(addr_o)); // R9
endmodule

bind ccag_addr_gen ccag_addr_gen_chk #(
  .ADDR_W      (ADDR_W),
  .SCREEN_LIMIT(SCREEN_LIMIT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_start_i (frame_start_i),
  .line_end_i    (line_end_i),
  .byte_adv_i    (byte_adv_i),
  .active_i      (active_i),
  .addr_o        (addr_o),
  .in_char_line_o(in_char_line_o)
);

// File: tb/ccag_addr_gen_tb_top.sv
module ccag_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  mode = 3'd0;
  logic        fs = 1'b0, le = 1'b0, ba = 1'b0, act = 1'b0;
  logic [15:0] addr;
  logic        inl;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int    m_addr, m_ls, m_line, m_size, m_rowh;
  bit    m_first;
  string m_tag;

  always #4 clk = ~clk;

  ccag_addr_gen dut_i (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode),
    .frame_start_i (fs),
    .line_end_i    (le),
    .byte_adv_i    (ba),
    .active_i      (act),
    .addr_o        (addr),
    .in_char_line_o(inl)
  );

  function automatic int exp_start(input int m);
    case (m)
      0, 1, 2: return 'h3000;
      3:       return 'h4100;
      4, 5:    return 'h5800;
      default: return 'h6000;
    endcase
  endfunction

  function automatic int exp_rowh(input int m);
    return (m == 3 || m >= 6) ? 10 : 8;
  endfunction

  function automatic int wrapf(input int v, input int size);
    return (v >= 'h8000) ? v - size : v;
  endfunction

  task automatic check(input string tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_step(input bit f, input bit l, input bit b, input bit a, input int md);
    int v;
    if (f) begin
      m_addr = exp_start(md); m_ls = m_addr; m_line = m_addr % 8;
      m_size = 'h8000 - m_addr; m_rowh = exp_rowh(md); m_first = 1;
      m_tag = (l || b) ? "R10" : "R2";
    end else if (l && a) begin
      if (m_first) begin
        m_first = 0; m_tag = "R6";
      end else begin
        m_line++;
        if (m_line == m_rowh) begin
          m_addr = wrapf(m_addr - 7, m_size); m_ls = m_addr; m_line = 0; m_tag = "R8";
        end else if (m_line >= 8) begin
          m_tag = "R9";
        end else begin
          m_addr = wrapf(m_ls + 1, m_size); m_ls = m_addr; m_tag = "R7";
        end
      end
      if (b) m_tag = "R10";
    end else if (b && a) begin
      if (m_line < 8) begin
        v = m_addr + 8;
        m_tag = (v >= 'h8000) ? "R5" : "R4";
        m_addr = wrapf(v, m_size);
      end else begin
        m_tag = "R9";
      end
    end else begin
      m_tag = "R11";
    end
  endtask

  // Called just after a falling edge: drive, model, then sample on the next falling edge.
  task automatic cyc(input bit f, input bit l, input bit b, input bit a);
    fs = f; le = l; ba = b; act = a;
    model_step(f, l, b, a, int'(mode));
    @(posedge clk);
    @(negedge clk);
    check(m_tag, int'(addr), m_addr, "addr_o");
    check(m_tag, int'(inl), (m_line < 8) ? 1 : 0, "in_char_line_o");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_addr = 'h6000; m_ls = 'h6000; m_line = 0; m_size = 'h2000; m_rowh = 10; m_first = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(addr), 'h6000, "addr_o");
    check("R1", int'(inl), 1, "in_char_line_o");
    rst = 1'b0;

    // R3: mode_i moves without a frame start; the mode-6 wrap size still applies.
    mode = 3'd0;
    for (int i = 0; i < 1024; i++) cyc(0, 0, 1, 1);
    check("R3", int'(addr), 'h6000, "addr_o after 1024 advances");

    // R5: mode 3 wraps by 0x3F00 after 2016 advances.
    mode = 3'd3;
    cyc(1, 0, 0, 1);
    for (int i = 0; i < 2015; i++) cyc(0, 0, 1, 1);
    check("R5", int'(addr), 'h7FF8, "addr_o before wrap");
    cyc(0, 0, 1, 1);
    check("R5", int'(addr), 'h4100, "addr_o after wrap");

    // R10: all strobes at once, frame start wins.
    mode = 3'd4;
    cyc(1, 1, 1, 1);
    check("R10", int'(addr), 'h5800, "addr_o");

    // R11: byte advance with active low is ignored.
    cyc(0, 0, 1, 0);
    check("R11", int'(addr), 'h5800, "addr_o");

    // Walk one 10-line row in mode 6 through the spacer lines.
    mode = 3'd6;
    cyc(1, 0, 0, 1);
    cyc(0, 1, 0, 1);                        // R6 first line end ignored
    check("R6", int'(addr), 'h6000, "addr_o");
    cyc(0, 0, 1, 1);
    cyc(0, 1, 0, 1);                        // R7 next line
    check("R7", int'(addr), 'h6001, "addr_o");
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 1);
    check("R7", int'(addr), 'h6007, "addr_o");
    cyc(0, 1, 0, 1);                        // line 8: spacer
    check("R9", int'(inl), 0, "in_char_line_o");
    cyc(0, 0, 1, 1);
    check("R9", int'(addr), 'h6007, "addr_o");
    cyc(0, 1, 0, 1);                        // line 9
    cyc(0, 1, 0, 1);                        // row end
    check("R8", int'(addr), 'h6000, "addr_o");
    check("R8", int'(inl), 1, "in_char_line_o");

    // Constrained random traffic
    for (int i = 0; i < 30000; i++) begin
      bit f, l, b, a;
      if ($urandom_range(0, 199) == 0) mode = 3'($urandom_range(0, 7));
      f = ($urandom_range(0, 2499) == 0);
      l = ($urandom_range(0, 9) == 0);
      b = ($urandom_range(0, 1) == 1);
      a = ($urandom_range(0, 7) != 0);
      cyc(f, l, b, a);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule